// File: doc/BRIEF.md
# Knob Reading Averager with Deadband

This block turns the raw readings of a control knob, delivered by an analog-to-digital converter as 10-bit values with a one-cycle ready strobe, into a stable 16-bit buffer-size setting. It sums a block of 256 readings and keeps the upper bits of the sum, which is the block average. The average is then held between a configured lower and upper limit.

The held setting changes only when the new clamped average is at least two counts away from it. This hysteresis keeps converter noise near a step from making the setting jump back and forth. The accumulator is cleared at the end of every block, so each block is averaged on its own. Logic downstream reads `size_out` as the requested size. Converter control and any use of the size lie outside this block.

Top module: `knob_size_filter`

## Requirements
- R1: While reset is asserted, and after it until the first completed block, `size_out` is 0.
- R2: `size_out` changes only on the clock edge that accepts the 256th counted reading of a block. It is stable at all other times.
- R3: The block average is the sum of the 256 readings of the block, shifted right by 8 bits and truncated toward zero.
- R4: A reading is counted only on a cycle where `conv_valid` is 1. On cycles where `conv_valid` is 0, the value of `conv_data` has no effect on the average.
- R5: An average below `min_lim` is replaced by `min_lim`.
- R6: An average at or above `max_lim` is replaced by `max_lim`. The lower limit is tested first.
- R7: If the clamped average differs from the held `size_out` by less than 2, `size_out` keeps its old value.
- R8: If the clamped average differs from the held `size_out` by 2 or more, `size_out` takes the clamped average.
- R9: The accumulator and the reading counter restart at the end of every block, whether or not `size_out` changed, so no reading is carried into the next block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_valid | input | 1 | One-cycle strobe marking a new converter reading |
| conv_data | input | 10 | Converter reading, unsigned |
| min_lim | input | 16 | Lower limit of the size setting |
| max_lim | input | 16 | Upper limit of the size setting |
| size_out | output | 16 | Held, filtered size setting |

## Verification
The bench builds the block with its defaults: 10-bit readings, blocks of 256 readings and a deadband of 2. Every block therefore passes through the real 8-bit counter wrap and the 24-bit accumulator. The lower limit is held at 2. The upper limit is a port, and the bench drops it to 600 so the ceiling becomes reachable with 10-bit readings. This exposes both the exact-at-maximum case and the case one count below it. Readings are also fed with idle cycles between them that carry full-scale junk data, and blocks mixing two values check truncation of the average. A full-scale block followed by a small one shows whether anything from the previous block leaks into the next.

// File: rtl/knob_pkg.sv
package knob_pkg;
  parameter int SIZE_W = 16;
  typedef logic [SIZE_W-1:0] size_t;

  // Lower limit wins: it is tested before the upper one.
  function automatic size_t clamp_size(input size_t v, input size_t lo, input size_t hi);
    if (v < lo)       return lo;
    else if (v >= hi) return hi;
    else              return v;
  endfunction

  function automatic size_t abs_gap(input size_t a, input size_t b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/knob_accum.sv
module knob_accum
  import knob_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LOG2_N   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                blk_end,
  output size_t               blk_avg
);
  localparam int SUM_W = SIZE_W + LOG2_N;

  logic [LOG2_N-1:0] cnt_q;
  logic [SUM_W-1:0]  acc_q;
  logic [SUM_W-1:0]  sum_next;

  assign sum_next = acc_q + {{(SUM_W-SAMPLE_W){1'b0}}, sample};
  // Counter starts at zero, wraps down, and the block closes on the reading taking it from 1 to 0.
  assign blk_end  = strobe && (cnt_q == LOG2_N'(1));
  assign blk_avg  = sum_next[SUM_W-1:LOG2_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (strobe) begin
      cnt_q <= cnt_q - LOG2_N'(1);
      acc_q <= blk_end ? '0 : sum_next;
    end
  end
endmodule

// File: rtl/knob_clamp.sv
module knob_clamp
  import knob_pkg::*;
(
  input  size_t raw,
  input  size_t lo,
  input  size_t hi,
  output size_t clamped
);
  assign clamped = clamp_size(raw, lo, hi);
endmodule

// File: rtl/knob_hold.sv
module knob_hold
  import knob_pkg::*;
#(
  parameter int DEADBAND = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  blk_end,
  input  size_t cand,
  output logic  take,
  output size_t held
);
  assign take = blk_end && (abs_gap(cand, held) >= SIZE_W'(DEADBAND));

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (take) held <= cand;
  end
endmodule

// File: rtl/knob_size_filter.sv
module knob_size_filter
  import knob_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LOG2_N   = 8,
  parameter int DEADBAND = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                conv_valid,
  input  logic [SAMPLE_W-1:0] conv_data,
  input  logic [SIZE_W-1:0]   min_lim,
  input  logic [SIZE_W-1:0]   max_lim,
  output logic [SIZE_W-1:0]   size_out
);
  logic  blk_end;
  logic  upd_take;
  size_t avg_raw;
  size_t avg_clamped;

  knob_accum #(.SAMPLE_W(SAMPLE_W), .LOG2_N(LOG2_N)) u_accum (
    .clk(clk), .rst(rst), .strobe(conv_valid), .sample(conv_data),
    .blk_end(blk_end), .blk_avg(avg_raw)
  );

  knob_clamp u_clamp (
    .raw(avg_raw), .lo(min_lim), .hi(max_lim), .clamped(avg_clamped)
  );

  knob_hold #(.DEADBAND(DEADBAND)) u_hold (
    .clk(clk), .rst(rst), .blk_end(blk_end), .cand(avg_clamped),
    .take(upd_take), .held(size_out)
  );
endmodule

// File: rtl/knob_size_filter_chk.sv
module knob_size_filter_chk
  import knob_pkg::*;
#(
  parameter int DEADBAND = 2
) (
  input logic  clk,
  input logic  rst,
  input logic  blk_end,
  input size_t avg_clamped,
  input size_t min_lim,
  input size_t max_lim,
  input size_t size_out
);
  // R1: reset clears the held setting
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (1'b0)
    rst |=> (size_out == '0));

  // R2: the setting only moves at a block boundary
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !blk_end |=> $stable(size_out));

  // R5: clamp output never below the lower limit
  p_floor_r5: assert property (@(posedge clk) disable iff (rst)
    blk_end |-> (avg_clamped >= min_lim));

  // R6: clamp output never above the upper limit when limits are ordered
  p_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
    (blk_end && (min_lim <= max_lim)) |-> (avg_clamped <= max_lim));

  // R7: small moves are swallowed
  p_deadband_r7: assert property (@(posedge clk) disable iff (rst)
    (blk_end && (abs_gap(avg_clamped, size_out) < SIZE_W'(DEADBAND))) |=> $stable(size_out));

  // R8: large moves are taken
  p_update_r8: assert property (@(posedge clk) disable iff (rst)
    (blk_end && (abs_gap(avg_clamped, size_out) >= SIZE_W'(DEADBAND))) |=> (size_out == $past(avg_clamped)));
endmodule

bind knob_size_filter knob_size_filter_chk #(.DEADBAND(DEADBAND)) u_chk (
  .clk(clk), .rst(rst), .blk_end(blk_end), .avg_clamped(avg_clamped),
  .min_lim(min_lim), .max_lim(max_lim), .size_out(size_out)
);

// File: tb/knob_size_filter_bench.sv
`timescale 1ns/1ps
module knob_size_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_valid = 1'b0;
  logic [9:0]  conv_data = '0;
  logic [15:0] min_lim = 16'd2;
  logic [15:0] max_lim = 16'hEB00;
  logic [15:0] size_out;

  int n_checks = 0;
  int n_fail   = 0;
  int held_m   = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  knob_size_filter u_knob_size_filter (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .min_lim(min_lim), .max_lim(max_lim), .size_out(size_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  // kind 0: constant a; kind 1: ramp i*4; kind 2: first half a, second half b
  task automatic feed_block(input string req, input int kind, input int a, input int b,
                            input bit gaps);
    int sum = 0;
    int avg, cl, gap;
    for (int i = 0; i < 256; i++) begin
      int v;
      v = (kind == 0) ? a : (kind == 1) ? ((i * 4) % 1024) : ((i < 128) ? a : b);
      @(negedge clk);
      if (i == 128) chk("R2 mid-block hold", int'(size_out), held_m);
      conv_valid = 1'b1;
      conv_data  = 10'(v);
      sum += v;
      if (gaps) begin
        @(negedge clk);
        conv_valid = 1'b0;
        conv_data  = 10'd1023;  // junk while idle: R4
      end
    end
    @(negedge clk);
    conv_valid = 1'b0;
    avg = sum / 256;
    if (avg < int'(min_lim))       cl = int'(min_lim);
    else if (avg >= int'(max_lim)) cl = int'(max_lim);
    else                           cl = avg;
    gap = (cl > held_m) ? cl - held_m : held_m - cl;
    if (gap >= 2) held_m = cl;
    chk(req, int'(size_out), held_m);
    repeat (3) @(negedge clk);
    chk("R2 idle hold", int'(size_out), held_m);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 during reset", int'(size_out), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 after reset", int'(size_out), 0);
  endtask

  task automatic t_average();
    feed_block("R3 R8 constant 500", 0, 500, 0, 0);
    chk("R3 value 500", int'(size_out), 500);
    feed_block("R3 ramp average 510", 1, 0, 0, 0);
    chk("R3 value 510", int'(size_out), 510);
  endtask

  task automatic t_gaps();
    feed_block("R4 gapped readings with junk", 0, 300, 0, 1);
    chk("R4 value 300", int'(size_out), 300);
  endtask

  task automatic t_deadband();
    feed_block("R7 diff 1 kept", 0, 301, 0, 0);
    chk("R7 value 300", int'(size_out), 300);
    feed_block("R8 diff 2 taken", 0, 302, 0, 0);
    chk("R8 value 302", int'(size_out), 302);
    feed_block("R3 R7 truncated 303", 2, 303, 304, 0);
    chk("R3 value 302", int'(size_out), 302);
  endtask

  task automatic t_min();
    feed_block("R5 zero raised to min", 0, 0, 0, 0);
    chk("R5 value 2", int'(size_out), 2);
    feed_block("R5 one raised to min", 0, 1, 0, 0);
    chk("R5 value still 2", int'(size_out), 2);
  endtask

  task automatic t_max();
    max_lim = 16'd600;
    feed_block("R6 above max", 0, 800, 0, 0);
    chk("R6 value 600", int'(size_out), 600);
    feed_block("R6 exactly max", 0, 600, 0, 0);
    feed_block("R7 one below max kept", 0, 599, 0, 0);
    chk("R7 value 600", int'(size_out), 600);
  endtask

  task automatic t_clear();
    feed_block("R9 full-scale block", 0, 1000, 0, 0);
    feed_block("R9 next block independent", 0, 100, 0, 0);
    chk("R9 value 100", int'(size_out), 100);
  endtask

  initial begin
    t_reset();
    t_average();
    t_gaps();
    t_deadband();
    t_min();
    t_max();
    t_clear();
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule